// File: doc/BRIEF.md
# Channel Filter and Level Stage

This block turns the single-bit tone or noise signal of each of four sound channels into a 4-bit output level. Each channel has its own control byte. Its low nibble sets the level applied while the channel bit is high. One bit of that byte overrides the channel bit, so the level follows the nibble alone. The block also takes a shared mode byte and one divider tick per channel. Each tick is a one-cycle enable in the master clock domain.

The first two channels can each be passed through a crude high-pass filter. A holding flop takes a copy of the channel bit whenever the tick of a partner channel arrives. The filtered bit is the exclusive-OR of the live bit and that held copy. Channel 0 is paired with channel 2's tick and channel 1 with channel 3's tick. Each filter has its own enable bit in the mode byte. A disabled filter clears its holding flop, so that a later enable starts from a known state.

Each level is registered, so it follows its inputs after one clock. A plain sum of the four registered levels is also provided for checking.

Top module: `chan_level_stage`

## Requirements
- R1: While reset is asserted, and after it is released, every level output and the sum read 0 until the first inputs are applied.
- R2: With a channel's force bit (control bit 4) low and its filter off, the channel's level one clock later is its control bits 3:0 if the channel bit was 1, and 0 if it was 0.
- R3: With control bit 4 high, the level one clock later equals control bits 3:0, whatever the channel bit, the ticks, the filter state or control bits 7:5.
- R4: A volume nibble of 0 gives level 0 in every case. A nibble of 15 gives level 15 whenever the level stage's input is high.
- R5: With mode bit 2 set, channel 0 uses the XOR of its bit and a held copy. The copy takes the channel-0 bit on a clock edge where tick 2 is high, and only then. Ticks 0, 1 and 3 leave it unchanged. The new copy affects the level computed on the following edge.
- R6: With mode bit 1 set, channel 1 is filtered in the same way, with the copy taken on tick 3.
- R7: While a channel's filter enable bit is clear, its held copy is forced to 0 and the channel is unfiltered. Re-enabling the filter therefore first passes the channel bit unchanged.
- R8: Channels 2 and 3 are never filtered, whatever the mode byte and the ticks.
- R9: The sum output always equals the sum of the four level outputs, and lies in the range 0 to 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_bit | input | 4 | Tone/noise bit per channel, index = channel |
| div_tick | input | 4 | One-cycle divider terminal pulse per channel |
| mode | input | 8 | Shared mode byte; bit 2 enables channel 0 filter, bit 1 enables channel 1 filter |
| chan_ctl | input | 32 | Control byte per channel (channel n in bits 8n+7:8n); bits 3:0 volume, bit 4 force |
| level_o | output | 16 | Registered 4-bit level per channel (channel n in bits 4n+3:4n) |
| level_sum_o | output | 6 | Sum of the four levels |

## Verification
On every cycle, assertions check three things: the force override, the silence produced by a low bit or a zero volume, and the holding flop's rules. The flop keeps its copy between partner ticks, samples on a tick and clears when disabled. Assertions also check that channels 2 and 3 stay unfiltered and that the sum stays in range. The bench's scenarios are needed to show the timing of the filter. A copy taken on a partner tick silences a steady bit only from the following level update, and an edge in the bit then passes through. They also show that ticks from the wrong channel are ignored and that re-enabling a filter starts clean.

// File: rtl/chan_level_pkg.sv
package chan_level_pkg;
  localparam int NCH       = 4;
  localparam int VOLW      = 4;
  localparam int CTLW      = 8;
  localparam int FORCE_BIT = 4;
  localparam int NFILT     = 2;
  localparam int SUMW      = $clog2(NCH * ((1 << VOLW) - 1) + 1);

  // Filtered channel f takes its tick from channel f + NFILT.
  function automatic int clk_src(input int f);
    return f + NFILT;
  endfunction

  // Filtered channel 0 uses mode bit 2 and channel 1 uses mode bit 1.
  function automatic int en_bit(input int f);
    return NFILT - f;
  endfunction
endpackage

// File: rtl/hp_filter.sv
module hp_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic bit_i,
  output logic bit_o
);
  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (!en_i)       hold_d = 1'b0;
    else if (tick_i) hold_d = bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign bit_o = en_i ? (bit_i ^ hold_q) : bit_i;

  p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i) |=> (hold_q == $past(hold_q)));
  p_sample_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i) |=> (hold_q == $past(bit_i)));
  p_clear_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (hold_q == 1'b0));
endmodule

// File: rtl/vol_stage.sv
module vol_stage #(
  parameter int VOLW      = 4,
  parameter int CTLW      = 8,
  parameter int FORCE_BIT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_i,
  input  logic [CTLW-1:0] ctl_i,
  output logic [VOLW-1:0] level_o
);
  logic [VOLW-1:0] vol;
  logic            force_on;
  logic [VOLW-1:0] level_d, level_q;

  assign vol      = ctl_i[VOLW-1:0];
  assign force_on = ctl_i[FORCE_BIT];

  always_comb begin
    level_d = '0;
    if (force_on || bit_i) level_d = vol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign level_o = level_q;

  p_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |=> (level_o == $past(vol)));
  p_low_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_on && !bit_i) |=> (level_o == '0));
  p_vol_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vol == '0) |=> (level_o == '0));
endmodule

// File: rtl/level_sum.sv
module level_sum #(
  parameter int NCH  = 4,
  parameter int VOLW = 4,
  parameter int SUMW = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0][VOLW-1:0]  level_i,
  output logic [SUMW-1:0]           sum_o
);
  localparam int MAXSUM = NCH * ((1 << VOLW) - 1);

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NCH; i++) sum_o = sum_o + SUMW'(level_i[i]);
  end

  p_sum_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sum_o) <= MAXSUM));
endmodule

// File: rtl/chan_level_stage.sv
module chan_level_stage
  import chan_level_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            chan_bit,
  input  logic [NCH-1:0]            div_tick,
  input  logic [7:0]                mode,
  input  logic [NCH-1:0][CTLW-1:0]  chan_ctl,
  output logic [NCH-1:0][VOLW-1:0]  level_o,
  output logic [SUMW-1:0]           level_sum_o
);
  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic [NCH-1:0] eff_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c < NFILT) begin : g_filt
      hp_filter i_hp (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .en_i   (mode[en_bit(c)]),
        .tick_i (div_tick[clk_src(c)]),
        .bit_i  (chan_bit[c]),
        .bit_o  (eff_bit[c])
      );
    end else begin : g_pass
      assign eff_bit[c] = chan_bit[c];

      p_unfiltered_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
        (chan_bit[c] && !chan_ctl[c][FORCE_BIT]) |=> (level_o[c] == $past(chan_ctl[c][VOLW-1:0])));
    end

    vol_stage #(.VOLW(VOLW), .CTLW(CTLW), .FORCE_BIT(FORCE_BIT)) i_vol (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .bit_i   (eff_bit[c]),
      .ctl_i   (chan_ctl[c]),
      .level_o (level_o[c])
    );
  end

  level_sum #(.NCH(NCH), .VOLW(VOLW), .SUMW(SUMW)) i_sum (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .level_i (level_o),
    .sum_o   (level_sum_o)
  );
endmodule

// File: tb/test_chan_level_stage.sv
module test_chan_level_stage;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        chan_bit = '0;
  logic [3:0]        div_tick = '0;
  logic [7:0]        mode = '0;
  logic [3:0][7:0]   chan_ctl = '0;
  logic [3:0][3:0]   level_o;
  logic [5:0]        level_sum_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chan_level_stage i_chan_level_stage (
    .clk(clk), .rst_n(rst_n), .chan_bit(chan_bit), .div_tick(div_tick),
    .mode(mode), .chan_ctl(chan_ctl), .level_o(level_o), .level_sum_o(level_sum_o)
  );

  // {channel bits, control bytes ch3..ch0, expected levels ch3..ch0}; filters off
  localparam logic [51:0] VEC [7] = '{
    52'hF090A0B0C9ABC, 52'h0090A0B0C0000, 52'h50F0F0F0F0F0F,
    52'h011151F1015F0, 52'hF00E010030003, 52'hAE7F2A5367256,
    52'hFFFFFFFFFFFFF
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_levels(input string req, input logic [15:0] exp);
    int s = 0;
    for (int i = 0; i < 4; i++) s += int'(exp[i*4 +: 4]);
    chk(req, int'(level_o), int'(exp));
    chk("R9", int'(level_sum_o), s);
  endtask

  task automatic step(input logic [3:0] b, input logic [3:0] t);
    @(negedge clk);
    chan_bit = b;
    div_tick = t;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_levels("R1", 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk_levels("R1", 16'h0000);

    // table walk: R2, R3, R4, R9
    for (int v = 0; v < 7; v++) begin
      @(negedge clk);
      chan_ctl = VEC[v][47:16];
      step(VEC[v][51:48], 4'b0000);
      chk_levels("R2/R3/R4", VEC[v][15:0]);
    end

    // R5: channel 0 filter via mode bit 2, partner tick 2
    @(negedge clk);
    mode = 8'h04;
    chan_ctl = 32'h00000005;
    step(4'b0001, 4'b0000);   chk_levels("R5", 16'h0005);
    step(4'b0001, 4'b0100);   chk_levels("R5", 16'h0005);
    step(4'b0001, 4'b0000);   chk_levels("R5", 16'h0000);
    step(4'b0000, 4'b0000);   chk_levels("R5", 16'h0005);
    step(4'b0001, 4'b1011);   chk_levels("R5", 16'h0000);
    step(4'b0001, 4'b0000);   chk_levels("R5", 16'h0000);
    // R3: force overrides the filter
    @(negedge clk);
    chan_ctl = 32'h00000017;
    step(4'b0001, 4'b0000);   chk_levels("R3", 16'h0007);
    // R7: disable clears the copy, re-enable passes bit straight
    @(negedge clk);
    chan_ctl = 32'h00000005;
    mode = 8'h00;
    step(4'b0001, 4'b0000);   chk_levels("R7", 16'h0005);
    @(negedge clk);
    mode = 8'h04;
    step(4'b0001, 4'b0000);   chk_levels("R7", 16'h0005);

    // R6: channel 1 filter via mode bit 1, partner tick 3
    @(negedge clk);
    mode = 8'h02;
    chan_ctl = 32'h00000900;
    step(4'b0010, 4'b0100);   chk_levels("R6", 16'h0090);
    step(4'b0010, 4'b0000);   chk_levels("R6", 16'h0090);
    step(4'b0010, 4'b1000);   chk_levels("R6", 16'h0090);
    step(4'b0010, 4'b0000);   chk_levels("R6", 16'h0000);

    // R8: channels 2 and 3 unfiltered under any mode and ticks
    @(negedge clk);
    mode = 8'hFF;
    chan_ctl = 32'h0C0A0000;
    step(4'b1100, 4'b1111);   chk_levels("R8", 16'hCA00);
    step(4'b1100, 4'b1111);   chk_levels("R8", 16'hCA00);
    step(4'b0100, 4'b0000);   chk_levels("R8", 16'h0A00);

    // R4: full volume on all, then zero
    @(negedge clk);
    mode = 8'h00;
    chan_ctl = 32'h0F0F0F0F;
    step(4'b1111, 4'b0000);   chk_levels("R4", 16'hFFFF);
    @(negedge clk);
    chan_ctl = 32'hF0F0F0F0;
    step(4'b1111, 4'b1111);   chk_levels("R4", 16'h0000);

    // R1: reset mid-run clears everything
    @(negedge clk);
    chan_ctl = 32'h1F1F1F1F;
    step(4'b1111, 4'b0000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_levels("R1", 16'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule